// File: doc/BRIEF.md
# Step-Iterated 256-bit ARX Permutation Core

This core applies a keyless permutation to a 256-bit state made of eight 32-bit words. The words are named x0, y0, x1, y1, x2, y2, x3, y3, and each (x, y) pair forms one branch. A caller presents a state and a step count, pulses `start`, and waits for `done`. The permuted state is then available on `state_out`.

Each step does three things in a fixed order. First it mixes the step index and a constant into branch 0 and branch 1. Next it runs each of the four branches through an add-rotate-xor box keyed by a per-branch constant. Last it applies a Feistel-like linear layer. In that layer, the left x-words feed the right y-words, the left y-words feed the right x-words, and the branches then rotate by one position and swap halves. The datapath is combinational across a whole step, so the core completes one step per clock.

Top module: `sparkle_perm256`

## Requirements
- R1: While `rst` is high and after its release with no `start`, `busy` and `done` are 0 and `state_out` is all zeros.
- R2: A `start` seen while idle captures `state_in` and `ns_in`. When `ns_in` is 0, `done` is high in the next cycle and `state_out` equals `state_in`.
- R3: When `ns_in` is n > 0, exactly n steps run, one per clock. `busy` is high during them and `done` rises n cycles after the `start` edge. `busy` and `done` are never high together.
- R4: `done` is high for exactly one cycle per run.
- R5: State word k occupies bits [32k+31:32k], in the order x0, y0, x1, y1, x2, y2, x3, y3. At the start of step s (counting from 0), y0 is XORed with constant c[s mod 8] and y1 is XORed with s. The constants are c[0..7] = B7E15162, BF715880, 38B4DA56, 324E7738, BB1185EB, 4F7C7B57, CFBFA1C8, C2B3293D.
- R6: Each branch i then passes through four rounds, each ending in x ^= c[i]. Using right rotation, the rounds are: x += rotr(y,31), y ^= rotr(x,24); x += rotr(y,17), y ^= rotr(x,17); x += y, y ^= rotr(x,31); x += rotr(y,24), y ^= rotr(x,16).
- R7: The linear layer uses f(t) = rotr(t ^ (t<<16), 16), with tx = f(x0^x1) and ty = f(y0^y1). The new y-words are y0 = y3^tx^y1, y1 = y2^tx^y0, y2 = y0, y3 = y1. The new x-words are x0 = x3^ty^x1, x1 = x2^ty^x0, x2 = x0, x3 = x1. Every right-hand side uses the values from before the layer.
- R8: A `start` that arrives while `busy` is high is ignored: the running result and its timing are unchanged.
- R9: After `done`, `state_out` holds the result until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| state_in | input | 256 | Initial state, word k at bits [32k+31:32k] |
| ns_in | input | NS_W | Number of steps to perform |
| state_out | output | 256 | Registered working/result state |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
The hardest cases to reach are the step counter wrapping past the eighth constant and the step index reaching its largest value in y1. Only long runs expose them, so the bench drives 8-step and 15-step runs and compares the result against its own step model. The bench also issues a second `start` in the middle of a run. It then checks that the result and the `done` timing still match an undisturbed run. Separate all-zero and single-bit input states isolate the constant injection from the mixing.

// File: rtl/sparkle_pkg.sv
package sparkle_pkg;
  localparam int WORD_W  = 32;
  localparam int NBRANCH = 4;
  localparam int NWORD   = 2 * NBRANCH;
  localparam int STATE_W = NWORD * WORD_W;
  localparam int NCONST  = 8;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t round_const(input logic [2:0] idx);
    case (idx)
      3'd0: return 32'hB7E15162;
      3'd1: return 32'hBF715880;
      3'd2: return 32'h38B4DA56;
      3'd3: return 32'h324E7738;
      3'd4: return 32'hBB1185EB;
      3'd5: return 32'h4F7C7B57;
      3'd6: return 32'hCFBFA1C8;
      default: return 32'hC2B3293D;
    endcase
  endfunction

  function automatic word_t rotr(input word_t v, input int n);
    return (v >> n) | (v << (WORD_W - n));
  endfunction
endpackage

// File: rtl/sparkle_arx.sv
module sparkle_arx
  import sparkle_pkg::*;
(
  input  word_t x_in,
  input  word_t y_in,
  input  word_t cst,
  output word_t x_out,
  output word_t y_out
);
  word_t x1, y1, x2, y2, x3, y3, x4, y4;

  always_comb begin
    x1 = x_in + rotr(y_in, 31);
    y1 = y_in ^ rotr(x1, 24);
    x1 = x1 ^ cst;
    x2 = x1 + rotr(y1, 17);
    y2 = y1 ^ rotr(x2, 17);
    x2 = x2 ^ cst;
    x3 = x2 + y2;
    y3 = y2 ^ rotr(x3, 31);
    x3 = x3 ^ cst;
    x4 = x3 + rotr(y3, 24);
    y4 = y3 ^ rotr(x4, 16);
    x4 = x4 ^ cst;
  end

  assign x_out = x4;
  assign y_out = y4;
endmodule

// File: rtl/sparkle_linear.sv
module sparkle_linear
  import sparkle_pkg::*;
(
  input  word_t xi [NBRANCH],
  input  word_t yi [NBRANCH],
  output word_t xo [NBRANCH],
  output word_t yo [NBRANCH]
);
  word_t tx, ty, mx, my;

  always_comb begin
    mx = xi[0] ^ xi[1];
    my = yi[0] ^ yi[1];
    tx = rotr(mx ^ (mx << 16), 16);
    ty = rotr(my ^ (my << 16), 16);
    yo[0] = yi[3] ^ tx ^ yi[1];
    yo[1] = yi[2] ^ tx ^ yi[0];
    yo[2] = yi[0];
    yo[3] = yi[1];
    xo[0] = xi[3] ^ ty ^ xi[1];
    xo[1] = xi[2] ^ ty ^ xi[0];
    xo[2] = xi[0];
    xo[3] = xi[1];
  end
endmodule

// File: rtl/sparkle_step.sv
module sparkle_step
  import sparkle_pkg::*;
#(
  parameter int NS_W = 4
) (
  input  logic [STATE_W-1:0] cur,
  input  logic [NS_W-1:0]    step_idx,
  output logic [STATE_W-1:0] nxt
);
  word_t xa [NBRANCH];
  word_t ya [NBRANCH];
  word_t xb [NBRANCH];
  word_t yb [NBRANCH];
  word_t xc [NBRANCH];
  word_t yc [NBRANCH];

  always_comb begin
    for (int b = 0; b < NBRANCH; b++) begin
      xa[b] = cur[(2*b)*WORD_W +: WORD_W];
      ya[b] = cur[(2*b+1)*WORD_W +: WORD_W];
    end
    ya[0] = ya[0] ^ round_const(step_idx[2:0]);
    ya[1] = ya[1] ^ WORD_W'(step_idx);
  end

  for (genvar g = 0; g < NBRANCH; g++) begin : g_box
    sparkle_arx u_box (
      .x_in (xa[g]),
      .y_in (ya[g]),
      .cst  (round_const(3'(g))),
      .x_out(xb[g]),
      .y_out(yb[g])
    );
  end

  sparkle_linear u_lin (.xi(xb), .yi(yb), .xo(xc), .yo(yc));

  always_comb begin
    for (int b = 0; b < NBRANCH; b++) begin
      nxt[(2*b)*WORD_W +: WORD_W]   = xc[b];
      nxt[(2*b+1)*WORD_W +: WORD_W] = yc[b];
    end
  end
endmodule

// File: rtl/sparkle_perm256.sv
module sparkle_perm256
  import sparkle_pkg::*;
#(
  parameter int NS_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [STATE_W-1:0] state_in,
  input  logic [NS_W-1:0]    ns_in,
  output logic [STATE_W-1:0] state_out,
  output logic               busy,
  output logic               done
);
  logic [STATE_W-1:0] st, st_next;
  logic [NS_W-1:0]    cnt, ns_r;

  sparkle_step #(.NS_W(NS_W)) u_step (.cur(st), .step_idx(cnt), .nxt(st_next));

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= '0;
      cnt  <= '0;
      ns_r <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          st   <= state_in;
          ns_r <= ns_in;
          cnt  <= '0;
          if (ns_in == '0) done <= 1'b1;
          else             busy <= 1'b1;
        end
      end else begin
        st  <= st_next;
        cnt <= cnt + 1'b1;
        if (cnt == NS_W'(ns_r - 1'b1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign state_out = st;

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R3
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst) !(busy && done));
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) busy |-> (cnt < ns_r));
  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(ns_r));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(state_out));
endmodule

// File: tb/tb_sparkle_perm256.sv
module tb_sparkle_perm256;
  localparam int NS_W = 4;
  logic clk = 1'b0;
  logic rst, start;
  logic [255:0] state_in;
  logic [NS_W-1:0] ns_in;
  logic [255:0] state_out;
  logic busy, done;
  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  sparkle_perm256 #(.NS_W(NS_W)) dut (.*);

  function automatic logic [31:0] rr(input logic [31:0] v, input int n);
    return {v, v} >> n;
  endfunction

  function automatic logic [31:0] kc(input int i);
    logic [31:0] t [8] = '{32'hB7E15162, 32'hBF715880, 32'h38B4DA56, 32'h324E7738,
                           32'hBB1185EB, 32'h4F7C7B57, 32'hCFBFA1C8, 32'hC2B3293D};
    return t[i % 8];
  endfunction

  function automatic logic [255:0] model(input logic [255:0] s0, input int ns);
    logic [31:0] w [8];
    logic [31:0] x, y, a, b, p, q, o [8];
    for (int k = 0; k < 8; k++) w[k] = s0[32*k +: 32];
    for (int s = 0; s < ns; s++) begin
      w[1] ^= kc(s);
      w[3] ^= 32'(s);
      for (int i = 0; i < 4; i++) begin
        x = w[2*i]; y = w[2*i+1];
        x = x + rr(y, 31); y = y ^ rr(x, 24); x = x ^ kc(i);
        x = x + rr(y, 17); y = y ^ rr(x, 17); x = x ^ kc(i);
        x = x + y;         y = y ^ rr(x, 31); x = x ^ kc(i);
        x = x + rr(y, 24); y = y ^ rr(x, 16); x = x ^ kc(i);
        w[2*i] = x; w[2*i+1] = y;
      end
      a = w[0] ^ w[2]; b = w[1] ^ w[3];
      p = rr(a ^ {a[15:0], 16'h0}, 16);
      q = rr(b ^ {b[15:0], 16'h0}, 16);
      o[1] = w[7] ^ p ^ w[3]; o[3] = w[5] ^ p ^ w[1]; o[5] = w[1]; o[7] = w[3];
      o[0] = w[6] ^ q ^ w[2]; o[2] = w[4] ^ q ^ w[0]; o[4] = w[0]; o[6] = w[2];
      w = o;
    end
    for (int k = 0; k < 8; k++) model[32*k +: 32] = w[k];
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Runs a permutation; optionally pulses start again mid-run.
  task automatic run(input string req, input logic [255:0] s, input int ns, input bit poke);
    int lat = 0;
    state_in = s; ns_in = NS_W'(ns); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && lat < 40) begin
      if (poke && lat == 2) begin start = 1'b1; state_in = ~s; ns_in = 4'd1; end
      else start = 1'b0;
      @(negedge clk); lat++;
    end
    start = 1'b0;
    check({req, " latency"}, 256'(lat), 256'(ns));
    check({req, " result"}, state_out, model(s, ns));
    @(negedge clk);
    check({req, " done pulse R4"}, 256'(done), 256'(0));
  endtask

  task automatic t_reset;  // R1
    check("R1 state", state_out, '0);
    check("R1 busy", 256'(busy), 256'(0));
    check("R1 done", 256'(done), 256'(0));
  endtask

  task automatic t_zero_steps;  // R2
    run("R2 ns=0", {8{32'h01234567}}, 0, 1'b0);
  endtask

  task automatic t_one_step;  // R5 R6 R7
    run("R5 R6 R7 ns=1 zero", '0, 1, 1'b0);
    run("R6 R7 ns=1 bit", 256'h1 << 37, 1, 1'b0);
  endtask

  task automatic t_multi;  // R3 R5
    run("R3 ns=4", {32'hDEADBEEF, 32'h0, 32'hCAFEF00D, 32'h1, 32'h12345678,
                    32'h9ABCDEF0, 32'hFFFFFFFF, 32'h80000000}, 4, 1'b0);
    run("R5 ns=8 wrap", {8{32'hA5A5A5A5}}, 8, 1'b0);
    run("R5 ns=15 max", '0, 15, 1'b0);
  endtask

  task automatic t_busy_start;  // R8
    run("R8 restart ignored", {4{64'h0F0F0F0F_33333333}}, 6, 1'b1);
  endtask

  task automatic t_hold;  // R9
    logic [255:0] keep;
    keep = state_out;
    state_in = '1;
    repeat (5) @(negedge clk);
    check("R9 hold", state_out, keep);
    check("R9 idle", 256'(busy), 256'(0));
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; state_in = '0; ns_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero_steps();
    t_one_step();
    t_multi();
    t_busy_start();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule